// File: doc/BRIEF.md
# Reconfigurable Array Logic Cell

This block is one cell of a fine-grained programmable logic array. It reads four neighbour signals (north, east, south, west) and taps four local bus lines: two running north-south and two running east-west. It produces two direct outputs, A and B, which always go to the adjacent cells. It also produces four bus outputs, each with its own drive enable. Resolving many drivers on one bus line is left to the array.

A 16-bit configuration word sets the cell's function, its input steering and its bus routing. The word is written through an addressed programming port. A write reaches this cell only when the address equals the cell's own identifier. One cell can therefore be reprogrammed while its neighbours keep running. A write can replace the whole word, change a single bit, or load one of four standard states. A build-time parameter turns the cell into a stub. The stub has no configuration storage, drives no bus line, ignores all inputs and outputs constant 0.

Top module: `plc_cell`

## Requirements
- R1: While reset is high, and in the cycle after it, out_a and out_b are 0 and bus_oe is 0. Reset clears the configuration word and the internal flip-flop.
- R2: A write changes the configuration only if prg_we is 1 and prg_addr equals CELL_ID at a rising clock edge. The new function appears after that edge, and the old function holds until then. A write to any other address leaves the outputs unchanged. prg_op 3 is a no-op.
- R3: With prg_op 0 the whole word is loaded from prg_data. The word layout is: [1:0] mode, [2] constant value, [4:3] A-input select, [6:5] B-input select, [8:7] select-line tap, [12:9] route function result onto bus line 0..3, [14:13] corner pass, [15] invert B. Neighbour select codes are 0 north, 1 east, 2 south, 3 west. Bus codes are 0 NS1, 1 NS2, 2 EW1, 3 EW2.
- R4: With prg_op 1, the configuration bit indexed by prg_data[3:0] takes the value prg_data[4]. All other bits keep their values.
- R5: With prg_op 2, prg_data[1:0] loads a standard state and clears all routing. The states are: 0 constant 0, 1 constant 1, 2 multiplexer with north as A, east as B and NS1 as select, 3 the same multiplexer registered. In mode 0 (constant), out_a equals the constant bit.
- R6: In mode 1 (multiplexer), out_a is the B input when the selected tap is 1, and the A input when it is 0. The output is combinational.
- R7: In mode 2 (registered), out_a is the multiplexer value captured at the previous rising clock edge. The flip-flop samples the multiplexer on every edge.
- R8: In mode 3, out_a is the AND of the A and B inputs.
- R9: out_b equals out_a XOR configuration bit 15.
- R10: When route bit 9+i is set, bus_oe[i] is 1 and bus_o[i] equals out_a.
- R11: Corner bit 13 drives NS1 (bus line 0) from the EW1 tap. Corner bit 14 drives NS2 (bus line 1) from the EW2 tap. A route bit on the same line takes priority.
- R12: A bus line that is not enabled shows bus_oe 0 and bus_o 0.
- R13: With STUB = 1, out_a, out_b, bus_o and bus_oe are always 0, whatever the inputs and programming.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Array clock |
| rst | input | 1 | Synchronous active-high reset |
| prg_we | input | 1 | Programming write strobe |
| prg_addr | input | AW | Target cell address |
| prg_op | input | 2 | 0 word, 1 single bit, 2 standard state, 3 no-op |
| prg_data | input | 16 | Write payload |
| nbr_i | input | 4 | Neighbour inputs: north, east, south, west |
| bus_i | input | 4 | Bus taps: NS1, NS2, EW1, EW2 |
| out_a | output | 1 | Function result to adjacent cells |
| out_b | output | 1 | Result, optionally inverted |
| bus_o | output | 4 | Bus drive values |
| bus_oe | output | 4 | Bus drive enables |

## Verification
A wrong configuration bit is visible at the ports no later than the first cycle after the bad write. It shows up when the input pattern exercises that bit: a wrong select picks the wrong neighbour, and a wrong route bit shows up as a spurious enable. A stale flip-flop shows only in registered mode, and then one cycle late. For this reason the reference model compares all outputs on every cycle, over many random input patterns. A misdecoded address shows up as a function change on a cycle where the model expects none.

// File: rtl/plc_pkg.sv
package plc_pkg;
  localparam int CFG_W  = 16;
  localparam int N_NBR  = 4;
  localparam int N_BUS  = 4;
  localparam int N_CORN = 2;
  localparam int IDX_W  = $clog2(CFG_W);

  typedef enum logic [1:0] {
    FN_CONST = 2'd0,
    FN_MUX   = 2'd1,
    FN_REG   = 2'd2,
    FN_AND   = 2'd3
  } fn_e;

  typedef enum logic [1:0] {
    OP_WORD   = 2'd0,
    OP_BIT    = 2'd1,
    OP_PRESET = 2'd2,
    OP_NONE   = 2'd3
  } op_e;

  typedef struct packed {
    logic              b_inv;
    logic [N_CORN-1:0] corner;
    logic [N_BUS-1:0]  a_route;
    logic [1:0]        sel_s;
    logic [1:0]        sel_b;
    logic [1:0]        sel_a;
    logic              const_val;
    fn_e               mode;
  } cfg_t;

  function automatic cfg_t std_state(input logic [1:0] idx);
    cfg_t c;
    c = '0;
    case (idx)
      2'd0: c.mode = FN_CONST;
      2'd1: begin c.mode = FN_CONST; c.const_val = 1'b1; end
      2'd2: begin c.mode = FN_MUX; c.sel_a = 2'd0; c.sel_b = 2'd1; c.sel_s = 2'd0; end
      default: begin c.mode = FN_REG; c.sel_a = 2'd0; c.sel_b = 2'd1; c.sel_s = 2'd0; end
    endcase
    return c;
  endfunction
endpackage

// File: rtl/plc_cfg_reg.sv
module plc_cfg_reg
  import plc_pkg::*;
#(
  parameter int AW      = 6,
  parameter int CELL_ID = 5
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          prg_we,
  input  logic [AW-1:0] prg_addr,
  input  logic [1:0]    prg_op,
  input  logic [CFG_W-1:0] prg_data,
  output cfg_t          cfg_q
);
  localparam logic [AW-1:0] MY_ADDR = AW'(CELL_ID);

  logic hit;
  cfg_t cfg_d;
  logic [CFG_W-1:0] bitw;

  assign hit = prg_we && (prg_addr == MY_ADDR);

  always_comb begin
    bitw = cfg_q;
    bitw[prg_data[IDX_W-1:0]] = prg_data[IDX_W];
    case (op_e'(prg_op))
      OP_WORD:   cfg_d = cfg_t'(prg_data);
      OP_BIT:    cfg_d = cfg_t'(bitw);
      OP_PRESET: cfg_d = std_state(prg_data[1:0]);
      default:   cfg_d = cfg_q;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst)      cfg_q <= '0;
    else if (hit) cfg_q <= cfg_d;
  end

  AST_CFG_HOLD: assert property (@(posedge clk) disable iff (rst)
    !hit |=> $stable(cfg_q)); // R2
  AST_BIT_SINGLE: assert property (@(posedge clk) disable iff (rst)
    (hit && prg_op == 2'd1) |=> ($countones(cfg_q ^ $past(cfg_q)) <= 1)); // R4
endmodule

// File: rtl/plc_func.sv
module plc_func
  import plc_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  cfg_t             cfg,
  input  logic [N_NBR-1:0] nbr_i,
  input  logic [N_BUS-1:0] bus_i,
  output logic             fn_a,
  output logic             fn_b
);
  logic in_a, in_b, in_s, mux, q;

  assign in_a = nbr_i[cfg.sel_a];
  assign in_b = nbr_i[cfg.sel_b];
  assign in_s = bus_i[cfg.sel_s];
  assign mux  = in_s ? in_b : in_a;

  always_ff @(posedge clk) begin
    if (rst) q <= 1'b0;
    else     q <= mux;
  end

  always_comb begin
    case (cfg.mode)
      FN_CONST: fn_a = cfg.const_val;
      FN_MUX:   fn_a = mux;
      FN_REG:   fn_a = q;
      default:  fn_a = in_a & in_b;
    endcase
  end

  assign fn_b = fn_a ^ cfg.b_inv;

  AST_REG_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
    (cfg.mode == FN_REG && $past(!rst)) |-> fn_a == $past(mux)); // R7
endmodule

// File: rtl/plc_bus_drv.sv
module plc_bus_drv
  import plc_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  cfg_t             cfg,
  input  logic             fn_a,
  input  logic [N_BUS-1:0] bus_i,
  output logic [N_BUS-1:0] bus_o,
  output logic [N_BUS-1:0] bus_oe
);
  for (genvar i = 0; i < N_BUS; i++) begin : g_line
    logic pass_en, pass_val;
    if (i < N_CORN) begin : g_corner
      assign pass_en  = cfg.corner[i];
      assign pass_val = bus_i[i + N_CORN];
    end else begin : g_plain
      assign pass_en  = 1'b0;
      assign pass_val = 1'b0;
    end
    assign bus_oe[i] = cfg.a_route[i] | pass_en;
    assign bus_o[i]  = cfg.a_route[i] ? fn_a : (pass_en ? pass_val : 1'b0);

    AST_IDLE_LOW: assert property (@(posedge clk) disable iff (rst)
      !bus_oe[i] |-> !bus_o[i]); // R12
  end
endmodule

// File: rtl/plc_cell.sv
module plc_cell
  import plc_pkg::*;
#(
  parameter int AW      = 6,
  parameter int CELL_ID = 5,
  parameter bit STUB    = 1'b0
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             prg_we,
  input  logic [AW-1:0]    prg_addr,
  input  logic [1:0]       prg_op,
  input  logic [15:0]      prg_data,
  input  logic [3:0]       nbr_i,
  input  logic [3:0]       bus_i,
  output logic             out_a,
  output logic             out_b,
  output logic [3:0]       bus_o,
  output logic [3:0]       bus_oe
);
  if (STUB) begin : g_stub
    assign out_a  = 1'b0;
    assign out_b  = 1'b0;
    assign bus_o  = '0;
    assign bus_oe = '0;
  end else begin : g_full
    cfg_t cfg;

    plc_cfg_reg #(.AW(AW), .CELL_ID(CELL_ID)) u_cfg (
      .clk(clk), .rst(rst), .prg_we(prg_we), .prg_addr(prg_addr),
      .prg_op(prg_op), .prg_data(prg_data), .cfg_q(cfg));

    plc_func u_func (
      .clk(clk), .rst(rst), .cfg(cfg), .nbr_i(nbr_i), .bus_i(bus_i),
      .fn_a(out_a), .fn_b(out_b));

    plc_bus_drv u_bus (
      .clk(clk), .rst(rst), .cfg(cfg), .fn_a(out_a), .bus_i(bus_i),
      .bus_o(bus_o), .bus_oe(bus_oe));

    AST_RST_QUIET: assert property (@(posedge clk)
      rst |=> (!out_a && !out_b && bus_oe == 4'b0)); // R1
    AST_CONST_OUT: assert property (@(posedge clk) disable iff (rst)
      cfg.mode == FN_CONST |-> out_a == cfg.const_val); // R5
    AST_ROUTE_DRIVE: assert property (@(posedge clk) disable iff (rst)
      cfg.a_route[0] |-> (bus_oe[0] && bus_o[0] == out_a)); // R10
    AST_CORNER_PASS: assert property (@(posedge clk) disable iff (rst)
      (cfg.corner[0] && !cfg.a_route[0]) |-> (bus_oe[0] && bus_o[0] == bus_i[2])); // R11
  end
endmodule

// File: tb/plc_cell_tb.sv
module plc_cell_tb;
  localparam int CLK_P = 10;
  localparam int AW    = 6;
  localparam int ID    = 5;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic prg_we = 1'b0;
  logic [AW-1:0] prg_addr = '0;
  logic [1:0] prg_op = 2'd3;
  logic [15:0] prg_data = '0;
  logic [3:0] nbr_i = '0, bus_i = '0;
  logic out_a, out_b, s_a, s_b;
  logic [3:0] bus_o, bus_oe, s_o, s_oe;

  int checks = 0, errors = 0;
  bit done = 0;
  logic [15:0] mcfg = '0;
  logic mq = 1'b0;

  always #(CLK_P/2) clk = ~clk;

  plc_cell #(.AW(AW), .CELL_ID(ID)) u_dut (
    .clk(clk), .rst(rst), .prg_we(prg_we), .prg_addr(prg_addr), .prg_op(prg_op),
    .prg_data(prg_data), .nbr_i(nbr_i), .bus_i(bus_i), .out_a(out_a), .out_b(out_b),
    .bus_o(bus_o), .bus_oe(bus_oe));

  plc_cell #(.AW(AW), .CELL_ID(ID), .STUB(1'b1)) u_stub (
    .clk(clk), .rst(rst), .prg_we(prg_we), .prg_addr(prg_addr), .prg_op(prg_op),
    .prg_data(prg_data), .nbr_i(nbr_i), .bus_i(bus_i), .out_a(s_a), .out_b(s_b),
    .bus_o(s_o), .bus_oe(s_oe));

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s at %0t: actual %h expected %h", tag, $time, act, exp);
    end
  endtask

  function automatic logic m_mux();
    logic a, b, s;
    a = nbr_i[mcfg[4:3]]; b = nbr_i[mcfg[6:5]]; s = bus_i[mcfg[8:7]];
    return s ? b : a;
  endfunction

  function automatic logic m_res();
    case (mcfg[1:0])
      2'd0: return mcfg[2];
      2'd1: return m_mux();
      2'd2: return mq;
      default: return nbr_i[mcfg[4:3]] & nbr_i[mcfg[6:5]];
    endcase
  endfunction

  task automatic compare_all();
    logic r;
    logic [3:0] eoe, eo;
    string tag;
    r = m_res();
    case (mcfg[1:0])
      2'd0: tag = "R5 const";
      2'd1: tag = "R6 mux";
      2'd2: tag = "R7 reg";
      default: tag = "R8 and";
    endcase
    for (int i = 0; i < 4; i++) begin
      eoe[i] = mcfg[9+i] | (i < 2 && mcfg[13+i]);
      eo[i]  = mcfg[9+i] ? r : ((i < 2 && mcfg[13+i]) ? bus_i[i+2] : 1'b0);
    end
    chk(tag, {7'd0, out_a}, {7'd0, r});
    chk("R9 out_b", {7'd0, out_b}, {7'd0, r ^ mcfg[15]});
    chk("R10/R11/R12 bus_oe", {4'd0, bus_oe}, {4'd0, eoe});
    chk("R10/R11/R12 bus_o", {4'd0, bus_o}, {4'd0, eo});
    chk("R13 stub", {2'd0, s_a, s_b, s_oe | s_o}, 8'd0);
  endtask

  task automatic step(input logic r, input logic we, input logic [AW-1:0] ad,
                      input logic [1:0] op, input logic [15:0] d,
                      input logic [3:0] nb, input logic [3:0] bs);
    rst = r; prg_we = we; prg_addr = ad; prg_op = op; prg_data = d;
    nbr_i = nb; bus_i = bs;
    #(CLK_P/2 - 1);
    if (!r) compare_all();
    @(posedge clk);
    if (r) begin
      mcfg = '0; mq = 1'b0;
    end else begin
      mq = m_mux();
      if (we && ad == AW'(ID)) begin
        case (op)
          2'd0: mcfg = d;
          2'd1: mcfg[d[3:0]] = d[4];
          2'd2: case (d[1:0])
                  2'd0: mcfg = 16'h0000;
                  2'd1: mcfg = 16'h0004;
                  2'd2: mcfg = 16'h0021;
                  default: mcfg = 16'h0022;
                endcase
          default: ;
        endcase
      end
    end
    @(negedge clk);
  endtask

  task automatic idle(input int n);
    for (int k = 0; k < n; k++)
      step(1'b0, 1'b0, '0, 2'd3, '0, 4'($urandom), 4'($urandom));
  endtask

  initial begin
    #(CLK_P * 150000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    for (int k = 0; k < 3; k++) step(1'b1, 1'b0, '0, 2'd3, '0, 4'hF, 4'hF);
    // R1: first cycle after reset, inputs all high
    rst = 1'b0; nbr_i = 4'hF; bus_i = 4'hF;
    #1;
    chk("R1 reset out_a", {7'd0, out_a}, 8'd0);
    chk("R1 reset bus_oe", {4'd0, bus_oe}, 8'd0);
    @(negedge clk);
    // R2: write to another cell is ignored; no-op op ignored
    step(1'b0, 1'b1, AW'(ID + 1), 2'd0, 16'h0204, 4'hF, 4'hF);
    step(1'b0, 1'b1, AW'(ID), 2'd3, 16'h0204, 4'hF, 4'hF);
    #1;
    chk("R2 foreign write ignored", {3'd0, out_a, bus_oe}, 8'd0);
    @(negedge clk);
    // R2: old function valid until the edge, new one after
    step(1'b0, 1'b1, AW'(ID), 2'd2, 16'h0001, 4'h0, 4'h0);
    #1;
    chk("R2 write applies after edge", {7'd0, out_a}, 8'd1);
    @(negedge clk);
    // R5: standard states
    for (int p = 0; p < 4; p++) begin
      step(1'b0, 1'b1, AW'(ID), 2'd2, 16'(p), 4'($urandom), 4'($urandom));
      idle(20);
    end
    // R3: whole-word configurations
    for (int k = 0; k < 60; k++) begin
      step(1'b0, 1'b1, AW'(ID), 2'd0, 16'($urandom), 4'($urandom), 4'($urandom));
      idle(8);
    end
    // R11: corner pass on NS1 from EW1, no route bit
    step(1'b0, 1'b1, AW'(ID), 2'd0, 16'h2000, 4'h0, 4'b0100);
    #1;
    chk("R11 corner pass", {6'd0, bus_oe[0], bus_o[0]}, 8'b11);
    @(negedge clk);
    // R4: single-bit writes
    for (int k = 0; k < 200; k++) begin
      step(1'b0, 1'b1, AW'(ID), 2'd1, 16'($urandom_range(0, 31)), 4'($urandom), 4'($urandom));
      idle(2);
    end
    // mixed random traffic, addresses near and at this cell
    for (int k = 0; k < 2500; k++)
      step(1'b0, 1'($urandom_range(0, 3) == 0), AW'(ID + $urandom_range(0, 1)),
           2'($urandom), 16'($urandom), 4'($urandom), 4'($urandom));
    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule